// File: doc/BRIEF.md
# Serial EEPROM Random-Read Master

This block is a two-wire bus master that reads one byte at a time from a 256-byte serial EEPROM. Each read is a random access. The master first sends a write-direction control byte and the word address. It does not stop there. It issues a repeated start, sends the read-direction control byte, clocks in one data byte, answers it with a not-acknowledge and closes the bus with a stop. The device address is fixed at 1010000, with all three page bits at zero. The write control byte is therefore 0xA0 and the read control byte is 0xA1.

Two request ports feed the same sequencer, and the hardware port has priority. The hardware port carries logical addresses used for configuration data such as subsystem IDs or product data. These pass through a fixed translation: the 8-bit logical address is inverted bit by bit, then 4 is subtracted modulo 256. This puts the read-only area (physical 0x80 to 0xFF) at a fixed base ahead of the writable area (physical 0x00 to 0x7F). The software port carries a physical address, which is sent to the bus unchanged.

Both bus lines are open-drain. An output-enable of 1 pulls the line low, and the SDA line is sampled back through `sda_in`. Every bus phase lasts `HALF_CLKS` system clocks. When the transfer ends, `done` pulses for one cycle with the byte and the acknowledge-error result.

Top module: `eeprom_rd_master`

## Requirements
- R1: After reset, and at all times while idle, `scl_oe` and `sda_oe` are 0 (both lines released), `busy` is 0 and `done` is 0.
- R2: A request is accepted only while `busy` is 0, and `busy` is 1 in the next cycle. If `hw_req` and `sw_req` are high in the same cycle, the hardware request is served. A request raised while `busy` is 1 is dropped and never starts a transfer.
- R3: The bus address of a hardware request is (bitwise NOT of `hw_addr`) minus 4, modulo 256. Examples: 251 gives 0x00, 124 gives 0x7F, 123 gives 0x80, 0xFC gives 0xFF.
- R4: A software request sends `sw_addr` to the bus unchanged.
- R5: A transfer runs in this order on the bus: START, 0xA0, word address, repeated START with no STOP before it, 0xA1, one data byte from the device, master NACK, STOP.
- R6: Bytes travel MSB first. SDA is sampled while SCL is high.
- R7: SCL and SDA never change in the same system clock. SDA changes while SCL is high only to form a START (falling) or a STOP (rising).
- R8: Within a byte, SCL rising edges are 3*`HALF_CLKS` clocks apart and SCL stays high for `HALF_CLKS` clocks.
- R9: If the device leaves SDA high on the ninth clock of 0xA0, of the word address or of 0xA1, the master issues STOP at once. `done` then pulses with `ack_err`=1 and `rd_data`=0x00. `ack_err` changes only in a `done` cycle.
- R10: On the ninth clock of the data byte the master releases SDA, giving a not-acknowledge.
- R11: `done` is a single-cycle pulse in the cycle `busy` falls, after the STOP. With `ack_err`=0, `rd_data` holds the byte received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | 1 | Hardware read request (logical address) |
| hw_addr | input | 8 | Logical address, remapped before use |
| sw_req | input | 1 | Software read request (physical address) |
| sw_addr | input | 8 | Physical address, used unchanged |
| busy | output | 1 | Transfer in progress |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled level of the SDA line |
| rd_data | output | 8 | Byte read, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| ack_err | output | 1 | Device failed to acknowledge, valid with `done` |

## Verification
The remap is exercised with the four corner logical addresses at the region boundaries. The software port is then given one of those same numeric values, so a remap applied on the wrong port shows up as a wrong word address and a wrong data byte. A device model refuses the acknowledge on each of the three sent bytes in turn, which tells an early STOP apart from a sequence that runs on. The device data is asymmetric, so a bit-order error cannot give the right byte. Simultaneous requests check the priority, and a request raised mid-transfer checks that a busy master ignores it.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

    localparam logic [6:0] DEV_ID  = 7'b1010000;
    localparam logic [7:0] CTRL_WR = {DEV_ID, 1'b0};
    localparam logic [7:0] CTRL_RD = {DEV_ID, 1'b1};
    localparam logic [3:0] ACK_BIT = 4'd8;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_START,
        PH_HOLD,
        PH_LOW,
        PH_SETUP,
        PH_HIGH,
        PH_RS_LOW,
        PH_RS_PREP,
        PH_STOP_LOW,
        PH_STOP_PREP,
        PH_STOP_HIGH
    } eerd_phase_e;

    typedef struct packed {
        eerd_phase_e phase;
        logic [1:0]  byte_idx;
        logic [3:0]  bit_idx;
        logic [7:0]  addr;
        logic [7:0]  shreg;
        logic        scl_oe;
        logic        sda_oe;
        logic        err;
        logic        done;
        logic        ack_err;
        logic [7:0]  rd_data;
    } eerd_seq_t;

endpackage

// File: rtl/eerd_remap.sv
module eerd_remap #(
    parameter int AW     = 8,
    parameter int OFFSET = 4
) (
    input  logic [AW-1:0] logical,
    output logic [AW-1:0] physical
);
    localparam logic [AW-1:0] OFS = AW'(OFFSET);

    always_comb begin
        physical = (~logical) - OFS;
    end
endmodule

// File: rtl/eerd_tick.sv
module eerd_tick #(
    parameter int HALF_CLKS = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int            CW  = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CW-1:0] LIM = CW'(HALF_CLKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || cnt_q == LIM) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
        tick = run && (cnt_q == LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/eerd_seq.sv
module eerd_seq
    import eerd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       req_valid,
    input  logic [7:0] req_addr,
    input  logic       sda_in,
    output logic       busy,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic [7:0] rd_data,
    output logic       done,
    output logic       ack_err
);
    localparam eerd_seq_t SEQ_RST = '{
        phase:    PH_IDLE,
        byte_idx: 2'd0,
        bit_idx:  4'd0,
        addr:     8'h00,
        shreg:    8'h00,
        scl_oe:   1'b0,
        sda_oe:   1'b0,
        err:      1'b0,
        done:     1'b0,
        ack_err:  1'b0,
        rd_data:  8'h00
    };

    eerd_seq_t s_d, s_q;
    logic [7:0] tx_byte;
    logic       pull_bit;

    always_comb begin
        case (s_q.byte_idx)
            2'd0:    tx_byte = CTRL_WR;
            2'd1:    tx_byte = s_q.addr;
            default: tx_byte = CTRL_RD;
        endcase
        if (s_q.bit_idx == ACK_BIT || s_q.byte_idx == 2'd3) begin
            pull_bit = 1'b0;
        end else begin
            pull_bit = ~tx_byte[3'd7 - s_q.bit_idx[2:0]];
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.phase    = PH_START;
                    s_d.addr     = req_addr;
                    s_d.byte_idx = 2'd0;
                    s_d.bit_idx  = 4'd0;
                    s_d.shreg    = 8'h00;
                    s_d.err      = 1'b0;
                end
            end
            PH_START: if (tick) begin
                s_d.sda_oe = 1'b1;
                s_d.phase  = PH_HOLD;
            end
            PH_HOLD: if (tick) begin
                s_d.scl_oe  = 1'b1;
                s_d.bit_idx = 4'd0;
                s_d.phase   = PH_LOW;
            end
            PH_LOW: if (tick) begin
                s_d.sda_oe = pull_bit;
                s_d.phase  = PH_SETUP;
            end
            PH_SETUP: if (tick) begin
                s_d.scl_oe = 1'b0;
                s_d.phase  = PH_HIGH;
            end
            PH_HIGH: if (tick) begin
                s_d.scl_oe = 1'b1;
                if (s_q.bit_idx != ACK_BIT) begin
                    if (s_q.byte_idx == 2'd3) begin
                        s_d.shreg = {s_q.shreg[6:0], sda_in};
                    end
                    s_d.bit_idx = s_q.bit_idx + 4'd1;
                    s_d.phase   = PH_LOW;
                end else if (s_q.byte_idx != 2'd3 && sda_in) begin
                    s_d.err   = 1'b1;
                    s_d.phase = PH_STOP_LOW;
                end else begin
                    s_d.bit_idx = 4'd0;
                    case (s_q.byte_idx)
                        2'd0: begin
                            s_d.byte_idx = 2'd1;
                            s_d.phase    = PH_LOW;
                        end
                        2'd1: begin
                            s_d.byte_idx = 2'd2;
                            s_d.phase    = PH_RS_LOW;
                        end
                        2'd2: begin
                            s_d.byte_idx = 2'd3;
                            s_d.phase    = PH_LOW;
                        end
                        default: s_d.phase = PH_STOP_LOW;
                    endcase
                end
            end
            PH_RS_LOW: if (tick) begin
                s_d.sda_oe = 1'b0;
                s_d.phase  = PH_RS_PREP;
            end
            PH_RS_PREP: if (tick) begin
                s_d.scl_oe = 1'b0;
                s_d.phase  = PH_START;
            end
            PH_STOP_LOW: if (tick) begin
                s_d.sda_oe = 1'b1;
                s_d.phase  = PH_STOP_PREP;
            end
            PH_STOP_PREP: if (tick) begin
                s_d.scl_oe = 1'b0;
                s_d.phase  = PH_STOP_HIGH;
            end
            PH_STOP_HIGH: if (tick) begin
                s_d.sda_oe  = 1'b0;
                s_d.phase   = PH_IDLE;
                s_d.done    = 1'b1;
                s_d.ack_err = s_q.err;
                s_d.rd_data = s_q.err ? 8'h00 : s_q.shreg;
            end
            default: s_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEQ_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.phase != PH_IDLE);
    assign scl_oe  = s_q.scl_oe;
    assign sda_oe  = s_q.sda_oe;
    assign rd_data = s_q.rd_data;
    assign done    = s_q.done;
    assign ack_err = s_q.ack_err;
endmodule

// File: rtl/eeprom_rd_master.sv
module eeprom_rd_master #(
    parameter int HALF_CLKS = 125,
    parameter int REMAP_OFS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_req,
    input  logic [7:0] hw_addr,
    input  logic       sw_req,
    input  logic [7:0] sw_addr,
    output logic       busy,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in,
    output logic [7:0] rd_data,
    output logic       done,
    output logic       ack_err
);
    logic [7:0] hw_phys;
    logic [7:0] req_addr;
    logic       req_valid;
    logic       tick;

    eerd_remap #(
        .AW     (8),
        .OFFSET (REMAP_OFS)
    ) u_remap (
        .logical  (hw_addr),
        .physical (hw_phys)
    );

    always_comb begin
        req_valid = hw_req | sw_req;
        req_addr  = hw_req ? hw_phys : sw_addr;
    end

    eerd_tick #(
        .HALF_CLKS (HALF_CLKS)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    eerd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .sda_in    (sda_in),
        .busy      (busy),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .rd_data   (rd_data),
        .done      (done),
        .ack_err   (ack_err)
    );
endmodule

// File: rtl/eerd_chk.sv
module eerd_chk (
    input logic clk,
    input logic rst_n,
    input logic hw_req,
    input logic sw_req,
    input logic busy,
    input logic scl_oe,
    input logic sda_oe,
    input logic done,
    input logic ack_err
);
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (hw_req || sw_req)) |=> busy);

    p_one_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_oe) |-> $stable(sda_oe));

    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack_err) |-> done);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind eeprom_rd_master eerd_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_req  (hw_req),
    .sw_req  (sw_req),
    .busy    (busy),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .done    (done),
    .ack_err (ack_err)
);

// File: tb/eeprom_rd_master_tb.sv
module eeprom_rd_master_tb;
    localparam int HALF = 4;
    localparam int EV_START = 256;
    localparam int EV_STOP  = 257;
    localparam int EV_MNACK = 258;
    localparam int EV_MACK  = 259;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_req = 1'b0;
    logic [7:0] hw_addr = 8'h00;
    logic       sw_req = 1'b0;
    logic [7:0] sw_addr = 8'h00;
    logic       busy, scl_oe, sda_oe, done, ack_err;
    logic [7:0] rd_data;
    logic       slave_pull = 1'b0;
    logic       scl_line, sda_line;

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | slave_pull);

    always #5 clk = ~clk;

    eeprom_rd_master #(.HALF_CLKS(HALF)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_req  (hw_req),
        .hw_addr (hw_addr),
        .sw_req  (sw_req),
        .sw_addr (sw_addr),
        .busy    (busy),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe),
        .sda_in  (sda_line),
        .rd_data (rd_data),
        .done    (done),
        .ack_err (ack_err)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_val(input logic [7:0] a);
        return 8'(a * 8'd7 + 8'h3C);
    endfunction

    function automatic logic [7:0] remap_ref(input logic [7:0] l);
        return 8'(8'hFF - l - 8'd4);
    endfunction

    typedef struct packed { logic [7:0] data; logic err; } res_t;
    res_t exp_q[$];
    int   exp_log[$];
    int   act_log[$];
    int   done_cnt = 0;

    // device model state
    int         bitn = -1;
    bit         mode_tx = 1'b0;
    bit         go_tx = 1'b0;
    logic [7:0] rsh = 8'h00, tsh = 8'h00, ptr = 8'h00;
    int         rx_cnt = 0, byte_total = 0;
    int         nack_idx = -1;
    bit         prev_scl = 1'b1, prev_sda = 1'b1;
    int         cyc = 0;
    bit         rec_en = 1'b0;
    int         rises[$];
    int         falls[$];

    always @(negedge clk) begin
        bit ack;
        cyc++;
        if (rst_n) begin
            if (prev_scl && scl_line && prev_sda && !sda_line) begin
                act_log.push_back(EV_START);
                bitn = -1; mode_tx = 1'b0; go_tx = 1'b0; rx_cnt = 0; slave_pull = 1'b0;
            end else if (prev_scl && scl_line && !prev_sda && sda_line) begin
                act_log.push_back(EV_STOP);
                bitn = -1; mode_tx = 1'b0; go_tx = 1'b0; rx_cnt = 0; byte_total = 0;
                slave_pull = 1'b0;
            end else if (scl_line && !prev_scl) begin
                if (rec_en) rises.push_back(cyc);
                if (bitn >= 0 && bitn < 8 && !mode_tx) rsh = {rsh[6:0], sda_line};
                if (bitn == 8 && mode_tx) begin
                    act_log.push_back(sda_line ? EV_MNACK : EV_MACK);
                    mode_tx = 1'b0;
                end
            end else if (!scl_line && prev_scl) begin
                if (rec_en) falls.push_back(cyc);
                if (bitn < 0) begin
                    bitn = 0;
                    slave_pull = 1'b0;
                end else if (bitn == 8) begin
                    bitn = 0;
                    if (go_tx) begin
                        mode_tx = 1'b1; go_tx = 1'b0;
                        tsh = mem_val(ptr);
                    end
                    slave_pull = mode_tx ? ~tsh[7] : 1'b0;
                end else begin
                    bitn++;
                    if (bitn == 8) begin
                        if (!mode_tx) begin
                            act_log.push_back(int'(rsh));
                            ack = 1'b1;
                            if (rx_cnt == 0) begin
                                if (rsh == 8'hA1) go_tx = 1'b1;
                                else if (rsh != 8'hA0) ack = 1'b0;
                            end else if (rx_cnt == 1) begin
                                ptr = rsh;
                            end
                            if (nack_idx == byte_total) ack = 1'b0;
                            if (!ack) go_tx = 1'b0;
                            rx_cnt++; byte_total++;
                            slave_pull = ack;
                        end else begin
                            slave_pull = 1'b0;
                        end
                    end else begin
                        slave_pull = mode_tx ? ~tsh[3'(7 - bitn)] : 1'b0;
                    end
                end
            end
            prev_scl = scl_line;
            prev_sda = ~(sda_oe | slave_pull);

            // scoreboard monitor
            if (done) begin
                res_t e;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rd_data == e.data, "R11/R3/R4/R6 rd_data", int'(rd_data), int'(e.data));
                    chk(ack_err == e.err, "R9 ack_err", int'(ack_err), int'(e.err));
                    chk(act_log.size() == exp_log.size(), "R5 bus event count",
                        act_log.size(), exp_log.size());
                    for (int i = 0; i < act_log.size() && i < exp_log.size(); i++) begin
                        chk(act_log[i] == exp_log[i], "R5/R10 bus event", act_log[i], exp_log[i]);
                    end
                end
                act_log.delete();
                exp_log.delete();
                done_cnt++;
            end
        end else begin
            prev_scl = 1'b1; prev_sda = 1'b1; bitn = -1; slave_pull = 1'b0;
        end
    end

    // driver side: expected items go into the queues
    task automatic push_expect(input logic [7:0] p, input int nk);
        res_t r;
        exp_log.push_back(EV_START);
        exp_log.push_back(8'hA0);
        if (nk != 0) exp_log.push_back(int'(p));
        if (nk != 0 && nk != 1) begin
            exp_log.push_back(EV_START);
            exp_log.push_back(8'hA1);
        end
        if (nk < 0) exp_log.push_back(EV_MNACK);
        exp_log.push_back(EV_STOP);
        r.err  = (nk >= 0);
        r.data = (nk >= 0) ? 8'h00 : mem_val(p);
        exp_q.push_back(r);
    endtask

    task automatic wait_done(input int start);
        while (done_cnt == start) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(input bit use_hw, input logic [7:0] a, input int nk);
        int start;
        push_expect(use_hw ? remap_ref(a) : a, nk);
        nack_idx = nk;
        start = done_cnt;
        @(negedge clk);
        hw_req = use_hw; sw_req = !use_hw;
        hw_addr = a; sw_addr = a;
        @(negedge clk);
        hw_req = 1'b0; sw_req = 1'b0;
        wait_done(start);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int start;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(scl_oe == 1'b0, "R1 scl_oe", int'(scl_oe), 0);
        chk(sda_oe == 1'b0, "R1 sda_oe", int'(sda_oe), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);

        // R3 remap corners, R8 timing on the first transfer
        rec_en = 1'b1;
        do_read(1'b1, 8'd251, -1);
        rec_en = 1'b0;
        chk(rises[1] - rises[0] == 3 * HALF, "R8 bit period", rises[1] - rises[0], 3 * HALF);
        chk(falls[1] - rises[0] == HALF, "R8 high phase", falls[1] - rises[0], HALF);
        do_read(1'b1, 8'd124, -1);
        do_read(1'b1, 8'd123, -1);
        do_read(1'b1, 8'hFC, -1);

        // R4 software port untranslated
        do_read(1'b0, 8'hFB, -1);
        do_read(1'b0, 8'h5A, -1);

        // R9 missing acknowledge on each sent byte
        do_read(1'b0, 8'h21, 0);
        do_read(1'b0, 8'h22, 1);
        do_read(1'b1, 8'h23, 2);
        nack_idx = -1;

        // R2 simultaneous requests: hardware wins
        push_expect(remap_ref(8'h10), -1);
        start = done_cnt;
        @(negedge clk);
        hw_req = 1'b1; hw_addr = 8'h10; sw_req = 1'b1; sw_addr = 8'h20;
        @(negedge clk);
        hw_req = 1'b0; sw_req = 1'b0;
        wait_done(start);

        // R2 request while busy is dropped
        push_expect(remap_ref(8'h44), -1);
        start = done_cnt;
        @(negedge clk);
        hw_req = 1'b1; hw_addr = 8'h44;
        @(negedge clk);
        hw_req = 1'b0;
        repeat (3) @(negedge clk);
        sw_req = 1'b1; sw_addr = 8'h33;
        @(negedge clk);
        sw_req = 1'b0;
        wait_done(start);
        repeat (40) @(negedge clk);
        chk(busy == 1'b0, "R2 busy after dropped request", int'(busy), 0);
        chk(act_log.size() == 0, "R2 no bus activity after drop", act_log.size(), 0);
        chk(exp_q.size() == 0, "R11 all results seen", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule